// File: doc/BRIEF.md
# Measurement Intercycle Sequencer

This block runs in the gap between two measurement cycles of a frequency or period counter. When the time-base divider signals that a measurement has ended, the sequencer arms its gate flag, holds the divider at full count, and walks a two-bit phase counter through three phases. On the way it emits a one-cycle transfer strobe that copies the accumulated count into the display latch. Then, one phase later, it emits a one-cycle clear strobe that zeroes the count. When the phase counter wraps back to zero, the divider hold is released, so the next measurement begins on the first input or clock pulse after release.

In repetitive operation every step after the first comes from a slow interval tick, nominally 0.08 s. The tick is divided down from the system clock, and the divider restarts at each sequence start. In manual operation the operator's transfer and clear commands move the phases forward instead, and the interval tick has no effect. The count chain, latch and display lie outside this block.

Top module: `meas_intercycle_ctrl`

## Requirements
- R1: While `rst_ni` is low, the outputs are idle at once: `xfer_o`=0, `clr_o`=0, `div_hold_o`=0, `gate_arm_o`=1. An asserted reset aborts a running sequence.
- R2: A `meas_end_i` pulse sampled while idle raises `div_hold_o` in the next cycle, and `gate_arm_o` drops in the same cycle.
- R3: In repetitive mode (`manual_mode_i`=0), `xfer_o` is high for exactly one cycle, TICK_DIV cycles after the start cycle.
- R4: In repetitive mode, `clr_o` is high for exactly one cycle, 2·TICK_DIV cycles after the start cycle. It is never high together with `xfer_o`.
- R5: `div_hold_o` stays high without a break for 3·TICK_DIV cycles from the start cycle, then falls.
- R6: `gate_arm_o` is always the complement of `div_hold_o`.
- R7: `meas_end_i` has no effect while a sequence runs. This includes the last cycle before the hold is released.
- R8: In manual mode only commands move the sequence forward. A `man_xfer_i` sampled in the first phase gives `xfer_o` for one cycle in the next cycle. A `man_clr_i` sampled after the transfer gives `clr_o` in the next cycle, and the hold is released the cycle after that. Interval ticks change nothing.
- R9: Commands are ignored when idle, when out of order (a clear before the transfer, a second transfer), and in repetitive mode.
- R10: The interval divider restarts at the start of each sequence, so the strobe timing is the same whatever the idle time before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| meas_end_i | input | 1 | Terminal pulse from the time-base divider marking the end of a measurement |
| manual_mode_i | input | 1 | 1 = manual (operator-stepped), 0 = repetitive (tick-stepped) |
| man_xfer_i | input | 1 | Operator transfer command (manual mode only) |
| man_clr_i | input | 1 | Operator clear command (manual mode only) |
| xfer_o | output | 1 | One-cycle strobe: copy the count into the display latch |
| clr_o | output | 1 | One-cycle strobe: zero the count |
| div_hold_o | output | 1 | Holds the time-base divider at full count |
| gate_arm_o | output | 1 | Gate flag re-armed; the next measurement may start |

## Verification
The hardest case to reach from the ports is a measurement-end pulse that lands on the final phase, in the single cycle before the hold falls. An error there would start a fresh sequence instead of ignoring the pulse. The bench counts clock cycles from the start pulse and drives the extra pulse exactly 3·TICK_DIV cycles later. The same bench also varies the idle time before a start so that the free-running interval divider sits at different phases. This shows that the restart makes every interval full length.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // Phase order is behaviour: the counter increments through it and wraps to idle.
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_HOLD = 2'b01,
    PH_SHOW = 2'b10,
    PH_ZERO = 2'b11
  } phase_e;

endpackage

// File: rtl/icc_tick_gen.sv
module icc_tick_gen #(
  parameter int unsigned TICK_DIV = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);

  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap = (cnt_q == LAST);
    if (restart_i)  cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else            cnt_d = cnt_q + CW'(1);
  end

  assign tick_o = wrap & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R10

  AST_TICK_QUIET_AFTER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o); // R10

endmodule

// File: rtl/icc_phase_ctr.sv
module icc_phase_ctr
  import icc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   adv_i,
  output phase_e phase_o,
  output logic   step_o
);

  phase_e phase_q, phase_d;
  logic   step_q, step_d;

  always_comb begin
    phase_d = phase_q;
    if (phase_q == PH_IDLE) begin
      if (start_i) phase_d = PH_HOLD;
    end else if (adv_i) begin
      phase_d = phase_e'(phase_q + 2'd1);
    end
    step_d = (phase_q != PH_IDLE) && adv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;

  AST_PHASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_q) != PH_IDLE) |-> ((phase_q == $past(phase_q)) ||
                                     (phase_q == phase_e'($past(phase_q) + 2'd1)))); // R3

  AST_PHASE_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q || (phase_q != $past(phase_q))); // R4

endmodule

// File: rtl/icc_step_sel.sv
module icc_step_sel
  import icc_pkg::*;
(
  input  logic   manual_i,
  input  logic   tick_i,
  input  logic   man_xfer_i,
  input  logic   man_clr_i,
  input  phase_e phase_i,
  output logic   adv_o
);

  always_comb begin
    adv_o = 1'b0;
    if (!manual_i) begin
      adv_o = tick_i;
    end else begin
      unique case (phase_i)
        PH_HOLD: adv_o = man_xfer_i;
        PH_SHOW: adv_o = man_clr_i;
        PH_ZERO: adv_o = 1'b1;
        default: adv_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/icc_gate_flag.sv
module icc_gate_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R2

endmodule

// File: rtl/meas_intercycle_ctrl.sv
module meas_intercycle_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic meas_end_i,
  input  logic manual_mode_i,
  input  logic man_xfer_i,
  input  logic man_clr_i,
  output logic xfer_o,
  output logic clr_o,
  output logic div_hold_o,
  output logic gate_arm_o
);

  phase_e phase;
  logic   step;
  logic   tick;
  logic   adv;
  logic   start;
  logic   done;
  logic   flag;

  assign start = meas_end_i & (phase == PH_IDLE);
  assign done  = adv & (phase == PH_ZERO);

  icc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start),
    .tick_o    (tick)
  );

  icc_step_sel u_sel (
    .manual_i   (manual_mode_i),
    .tick_i     (tick),
    .man_xfer_i (man_xfer_i),
    .man_clr_i  (man_clr_i),
    .phase_i    (phase),
    .adv_o      (adv)
  );

  icc_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .adv_i   (adv),
    .phase_o (phase),
    .step_o  (step)
  );

  icc_gate_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (start),
    .clr_i  (done),
    .flag_o (flag)
  );

  // Three decode gates on the phase counter.
  assign xfer_o     = step & (phase == PH_SHOW);
  assign clr_o      = step & (phase == PH_ZERO);
  assign div_hold_o = (phase != PH_IDLE);
  assign gate_arm_o = ~flag;

  AST_HOLD_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_end_i && !div_hold_o) |=> div_hold_o); // R2

  AST_XFER_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o); // R3

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o); // R4

  AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_o && clr_o)); // R4

  AST_CLR_UNDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> div_hold_o); // R5

  AST_ARM_VS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_arm_o == !div_hold_o); // R6

endmodule

// File: tb/meas_intercycle_ctrl_tb.sv
`timescale 1ns/1ps
module meas_intercycle_ctrl_tb;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_end = 1'b0;
  logic manual = 1'b0;
  logic mx = 1'b0;
  logic mc = 1'b0;
  logic xfer_o, clr_o, div_hold_o, gate_arm_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  meas_intercycle_ctrl #(.TICK_DIV(N)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .meas_end_i    (meas_end),
    .manual_mode_i (manual),
    .man_xfer_i    (mx),
    .man_clr_i     (mc),
    .xfer_o        (xfer_o),
    .clr_o         (clr_o),
    .div_hold_o    (div_hold_o),
    .gate_arm_o    (gate_arm_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(xfer_o == 0 && clr_o == 0, "R1", "strobes in reset", xfer_o + clr_o, 0);
    check(div_hold_o == 0 && gate_arm_o == 1, "R1", "hold/arm in reset", div_hold_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(div_hold_o == 0 && gate_arm_o == 1, "R1", "idle after release", div_hold_o, 0);
  endtask

  // Repetitive run; end_k/cmd_k inject a stray pulse at that sample index (0 = none).
  task automatic run_rep(input string tag, input int pre_idle, input int end_k,
                         input int cmd_k, input string xreq);
    int fx = -1, fc = -1, fh = -1, fa = -1;
    manual = 1'b0;
    repeat (pre_idle) @(negedge clk);
    meas_end = 1'b1;
    @(negedge clk);
    meas_end = 1'b0;
    check(div_hold_o == 1 && gate_arm_o == 0, "R2", {tag, " hold at once"}, div_hold_o, 1);
    for (int k = 1; k <= 3 * N + 2; k++) begin
      logic ex, ec, eh;
      ex = (k == N + 1);
      ec = (k == 2 * N + 1);
      eh = (k <= 3 * N);
      if (xfer_o !== ex && fx < 0) fx = k;
      if (clr_o !== ec && fc < 0) fc = k;
      if (div_hold_o !== eh && fh < 0) fh = k;
      if (gate_arm_o !== !eh && fa < 0) fa = k;
      meas_end = (k == end_k);
      mx = (k == cmd_k);
      mc = (k == cmd_k);
      @(negedge clk);
    end
    meas_end = 1'b0; mx = 1'b0; mc = 1'b0;
    check(fx < 0, "R3", {tag, " xfer first wrong sample"}, fx, N + 1);
    check(fc < 0, "R4", {tag, " clr first wrong sample"}, fc, 2 * N + 1);
    check(fh < 0, "R5", {tag, " hold first wrong sample"}, fh, 3 * N);
    check(fa < 0, "R6", {tag, " arm first wrong sample"}, fa, 3 * N);
    if (xreq != "")
      check(fx < 0 && fc < 0 && fh < 0, xreq, {tag, " timing unchanged"}, fh, -1);
  endtask

  task automatic t_manual();
    int bad = 0;
    manual = 1'b1;
    @(negedge clk);
    mx = 1'b1; @(negedge clk); mx = 1'b0; mc = 1'b1; @(negedge clk); mc = 1'b0;
    check(div_hold_o == 0 && xfer_o == 0 && clr_o == 0, "R9", "commands while idle", div_hold_o, 0);
    meas_end = 1'b1; @(negedge clk); meas_end = 1'b0;
    check(div_hold_o == 1, "R2", "manual start hold", div_hold_o, 1);
    mc = 1'b1; @(negedge clk); mc = 1'b0;
    check(clr_o == 0 && div_hold_o == 1, "R9", "clear before transfer", clr_o, 0);
    for (int k = 0; k < 3 * N; k++) begin
      if (xfer_o || clr_o || !div_hold_o) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8", "ticks do not step manual", bad, 0);
    mx = 1'b1; @(negedge clk); mx = 1'b0;
    check(xfer_o == 1 && div_hold_o == 1, "R8", "xfer after command", xfer_o, 1);
    @(negedge clk);
    check(xfer_o == 0 && div_hold_o == 1, "R8", "xfer single cycle", xfer_o, 0);
    mx = 1'b1; @(negedge clk); mx = 1'b0;
    check(xfer_o == 0, "R9", "second transfer ignored", xfer_o, 0);
    bad = 0;
    for (int k = 0; k < 2 * N; k++) begin
      if (clr_o || xfer_o || !div_hold_o) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8", "waits for clear command", bad, 0);
    mc = 1'b1; @(negedge clk); mc = 1'b0;
    check(clr_o == 1 && div_hold_o == 1, "R8", "clr after command", clr_o, 1);
    @(negedge clk);
    check(clr_o == 0 && div_hold_o == 0 && gate_arm_o == 1, "R8", "release after clear", div_hold_o, 0);
    manual = 1'b0;
  endtask

  task automatic t_reset_abort();
    meas_end = 1'b1; @(negedge clk); meas_end = 1'b0;
    repeat (N + 3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(div_hold_o == 0 && gate_arm_o == 1, "R1", "reset aborts sequence", div_hold_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * N) @(negedge clk);
    check(xfer_o == 0 && clr_o == 0 && div_hold_o == 0, "R1", "stays idle after abort", div_hold_o, 0);
  endtask

  initial begin
    wait (cyc >= 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_rep("plain", 2, 0, 0, "");
    run_rep("offset3", 3, 0, 0, "R10");
    run_rep("offset5", 5, 0, 0, "R10");
    run_rep("end mid", 1, N + 3, 0, "R7");
    run_rep("end last", 2, 3 * N, 0, "R7");
    run_rep("cmd hold", 4, 0, N - 2, "R9");
    run_rep("cmd show", 1, 0, N + 2, "R9");
    t_manual();
    t_reset_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule